// File: doc/BRIEF.md
# MMU Fault Exception Router

This block takes one fault event from the translation and protection checks of a 64-bit hashed-page MMU. It decides which exception class the fault raises and captures the syndrome state that goes with it. The fault event carries a strobe, an access kind (load, store or fetch), four check-result flags, the faulting address, three machine-state bits and two partition mode bits. The block first picks the first check that failed, in a fixed priority order, and builds the syndrome word for it. It then routes the fault either to the supervisor class (ISI for fetches, DSI for data) or to the hypervisor class (HISI, HDSI). A captured exception pulse, a one-hot class select and an error code come out one clock later. The supervisor and hypervisor address and syndrome register pairs also come out.

The fault input is a plain strobe that is accepted in every cycle, and nothing ever stalls it. There is no ready signal, so the upstream MMU never sees back-pressure. Each fault is fully processed in the cycle it is presented. The exception pulse lasts exactly one cycle. The class select, error code and register pairs hold their values until a later fault changes them, or until the synchronous reset clears them.

Top module: `mmu_fault_router`

## Requirements
- R1: For a fetch fault, the mode bit is `part_vpm1` when `msr_ir` is 1 and `part_vpm0` when `msr_ir` is 0. The fault raises HISI when the selected bit is 1 and `msr_hv` is 0, and raises ISI in every other case. As a result, both partition bits at zero always give ISI.
- R2: For a load or store fault, the same selection is made using `msr_dr` in place of `msr_ir`. The fault raises HDSI when the selected bit is 1 and `msr_hv` is 0, and raises DSI otherwise.
- R3: An HDSI writes the faulting address to `hyp_addr` and the syndrome to `hyp_synd`. A DSI writes them to `sup_addr` and `sup_synd`. The pair that is not written keeps its value. ISI and HISI change none of the four registers.
- R4: For ISI and HISI, `err_code` equals the syndrome. For DSI and HDSI, `err_code` is 0.
- R5: A fetch with `seg_noexec` set gives syndrome 0x10000000. `seg_noexec` has no effect on loads and stores.
- R6: A page-table miss (`pte_miss`) gives syndrome 0x40000000 for a load or a fetch, and 0x42000000 for a store.
- R7: A fetch with `pp_deny` or `amr_deny` set gives syndrome 0x08000000.
- R8: For a data-access denial, the syndrome is built from three bits. `pp_deny` sets 0x08000000, `amr_deny` sets 0x00200000, and a store adds 0x02000000. Both deny bits may be set at the same time.
- R9: The checks are taken in a fixed order: segment no-execute first, then page-table miss, then access denial. Only the first check that fails is reported.
- R10: A fault accepted in cycle n updates the outputs at the next clock edge. `exc_valid` is then high for exactly one cycle. `exc_sel` is one-hot with bit 0 = ISI, bit 1 = HISI, bit 2 = DSI and bit 3 = HDSI. All outputs other than `exc_valid` hold their values between faults.
- R11: Access kind encoding is 0 = load, 1 = store, 2 = fetch, and 3 is illegal. Kind 3 raises no exception and leaves every output register unchanged. A strobe for which no check applies behaves the same way.
- R12: A synchronous reset (`rst` = 1) clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_valid | input | 1 | Fault strobe, accepted every cycle |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 illegal |
| seg_noexec | input | 1 | Segment is marked no-execute |
| pte_miss | input | 1 | Page-table lookup missed |
| pp_deny | input | 1 | Page protection lacks the needed right |
| amr_deny | input | 1 | Authority mask lacks the needed right |
| flt_addr | input | ADDR_W | Faulting effective address |
| msr_ir | input | 1 | Instruction relocation on |
| msr_dr | input | 1 | Data relocation on |
| msr_hv | input | 1 | Processor in hypervisor state |
| part_vpm0 | input | 1 | Partition mode bit used when relocation is off |
| part_vpm1 | input | 1 | Partition mode bit used when relocation is on |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_sel | output | 4 | One-hot class: bit0 ISI, bit1 HISI, bit2 DSI, bit3 HDSI |
| err_code | output | 32 | Error code of the last exception |
| sup_addr | output | ADDR_W | Supervisor fault address register |
| sup_synd | output | 32 | Supervisor syndrome register |
| hyp_addr | output | ADDR_W | Hypervisor fault address register |
| hyp_synd | output | 32 | Hypervisor syndrome register |

## Verification
The bench sweeps all combinations of relocation, hypervisor state and the two partition bits on both the fetch side and the data side. A design that picked the wrong mode bit, or ignored hypervisor state, would send faults to the wrong class and write the wrong register pair. Several flags are raised together to test the priority order. A router that let a miss override a no-execute fetch, or merged denial bits into a miss, would produce a different syndrome. Illegal access kinds, strobes with no failing check and no-execute on data accesses are sent to catch a design that latches anyway and corrupts the held registers. A reset in mid-run and a long run of random faults cover the hold and clear behaviour.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

  localparam int SYND_W = 32;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;

  // bit position in the one-hot class select
  localparam int CLS_ISI  = 0;
  localparam int CLS_HISI = 1;
  localparam int CLS_DSI  = 2;
  localparam int CLS_HDSI = 3;
  localparam int CLS_N    = 4;

  localparam logic [SYND_W-1:0] SY_NOEXEC = 32'h1000_0000;
  localparam logic [SYND_W-1:0] SY_MISS   = 32'h4000_0000;
  localparam logic [SYND_W-1:0] SY_PPROT  = 32'h0800_0000;
  localparam logic [SYND_W-1:0] SY_AMASK  = 32'h0020_0000;
  localparam logic [SYND_W-1:0] SY_STORE  = 32'h0200_0000;

  typedef struct packed {
    logic              hit;
    logic              inst;
    logic [SYND_W-1:0] synd;
  } fault_dec_t;

endpackage

// File: rtl/mfr_classify.sv
module mfr_classify
  import mfr_pkg::*;
(
  input  logic       [1:0] acc_kind,
  input  logic             seg_noexec,
  input  logic             pte_miss,
  input  logic             pp_deny,
  input  logic             amr_deny,
  output fault_dec_t       dec
);

  acc_kind_e kind;
  logic      is_fetch;
  logic      is_store;
  logic      any_deny;
  logic [SYND_W-1:0] st_bit;
  logic [SYND_W-1:0] deny_bits;

  assign kind      = acc_kind_e'(acc_kind);
  assign is_fetch  = (kind == ACC_FETCH);
  assign is_store  = (kind == ACC_STORE);
  assign any_deny  = pp_deny | amr_deny;
  assign st_bit    = is_store ? SY_STORE : '0;
  assign deny_bits = (pp_deny ? SY_PPROT : '0) | (amr_deny ? SY_AMASK : '0);

  always_comb begin
    dec      = '0;
    dec.inst = is_fetch;
    unique case (kind)
      ACC_FETCH: begin
        if (seg_noexec) begin
          dec.hit  = 1'b1;
          dec.synd = SY_NOEXEC;
        end else if (pte_miss) begin
          dec.hit  = 1'b1;
          dec.synd = SY_MISS;
        end else if (any_deny) begin
          dec.hit  = 1'b1;
          dec.synd = SY_PPROT;
        end
      end
      ACC_LOAD, ACC_STORE: begin
        if (pte_miss) begin
          dec.hit  = 1'b1;
          dec.synd = SY_MISS | st_bit;
        end else if (any_deny) begin
          dec.hit  = 1'b1;
          dec.synd = deny_bits | st_bit;
        end
      end
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/mfr_route.sv
module mfr_route
  import mfr_pkg::*;
(
  input  logic             inst,
  input  logic             msr_ir,
  input  logic             msr_dr,
  input  logic             msr_hv,
  input  logic             part_vpm0,
  input  logic             part_vpm1,
  output logic             to_hyp,
  output logic [CLS_N-1:0] cls
);

  logic reloc;
  logic mode_bit;

  assign reloc    = inst ? msr_ir : msr_dr;
  assign mode_bit = reloc ? part_vpm1 : part_vpm0;
  assign to_hyp   = mode_bit & ~msr_hv;

  always_comb begin
    cls = '0;
    if (inst) cls[to_hyp ? CLS_HISI : CLS_ISI] = 1'b1;
    else      cls[to_hyp ? CLS_HDSI : CLS_DSI] = 1'b1;
  end

endmodule

// File: rtl/mfr_capture.sv
module mfr_capture
  import mfr_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              inst,
  input  logic              to_hyp,
  input  logic [CLS_N-1:0]  cls,
  input  logic [SYND_W-1:0] synd,
  input  logic [ADDR_W-1:0] addr,
  output logic              exc_valid,
  output logic [CLS_N-1:0]  exc_sel,
  output logic [SYND_W-1:0] err_code,
  output logic [ADDR_W-1:0] sup_addr,
  output logic [SYND_W-1:0] sup_synd,
  output logic [ADDR_W-1:0] hyp_addr,
  output logic [SYND_W-1:0] hyp_synd
);

  localparam int BANKS = 2;  // 0 supervisor, 1 hypervisor

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_sel   <= '0;
      err_code  <= '0;
    end else begin
      exc_valid <= take;
      if (take) begin
        exc_sel  <= cls;
        err_code <= inst ? synd : '0;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ADDR_W-1:0] a_q;
    logic [SYND_W-1:0] s_q;
    logic              wr;
    assign wr = take & ~inst & (to_hyp == (b == 1));
    always_ff @(posedge clk) begin
      if (rst) begin
        a_q <= '0;
        s_q <= '0;
      end else if (wr) begin
        a_q <= addr;
        s_q <= synd;
      end
    end
  end

  assign sup_addr = g_bank[0].a_q;
  assign sup_synd = g_bank[0].s_q;
  assign hyp_addr = g_bank[1].a_q;
  assign hyp_synd = g_bank[1].s_q;

endmodule

// File: rtl/mmu_fault_router.sv
module mmu_fault_router
  import mfr_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic [1:0]        acc_kind,
  input  logic              seg_noexec,
  input  logic              pte_miss,
  input  logic              pp_deny,
  input  logic              amr_deny,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              msr_ir,
  input  logic              msr_dr,
  input  logic              msr_hv,
  input  logic              part_vpm0,
  input  logic              part_vpm1,
  output logic              exc_valid,
  output logic [3:0]        exc_sel,
  output logic [31:0]       err_code,
  output logic [ADDR_W-1:0] sup_addr,
  output logic [31:0]       sup_synd,
  output logic [ADDR_W-1:0] hyp_addr,
  output logic [31:0]       hyp_synd
);

  fault_dec_t       dec;
  logic             to_hyp;
  logic [CLS_N-1:0] cls;
  logic             take;

  mfr_classify u_classify (
    .acc_kind   (acc_kind),
    .seg_noexec (seg_noexec),
    .pte_miss   (pte_miss),
    .pp_deny    (pp_deny),
    .amr_deny   (amr_deny),
    .dec        (dec)
  );

  mfr_route u_route (
    .inst      (dec.inst),
    .msr_ir    (msr_ir),
    .msr_dr    (msr_dr),
    .msr_hv    (msr_hv),
    .part_vpm0 (part_vpm0),
    .part_vpm1 (part_vpm1),
    .to_hyp    (to_hyp),
    .cls       (cls)
  );

  assign take = flt_valid & dec.hit;

  mfr_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .inst      (dec.inst),
    .to_hyp    (to_hyp),
    .cls       (cls),
    .synd      (dec.synd),
    .addr      (flt_addr),
    .exc_valid (exc_valid),
    .exc_sel   (exc_sel),
    .err_code  (err_code),
    .sup_addr  (sup_addr),
    .sup_synd  (sup_synd),
    .hyp_addr  (hyp_addr),
    .hyp_synd  (hyp_synd)
  );

endmodule

// File: rtl/mfr_checker.sv
module mfr_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              flt_valid,
  input logic [1:0]        acc_kind,
  input logic              msr_hv,
  input logic              part_vpm0,
  input logic              part_vpm1,
  input logic              exc_valid,
  input logic [3:0]        exc_sel,
  input logic [31:0]       err_code,
  input logic [ADDR_W-1:0] sup_addr,
  input logic [31:0]       sup_synd,
  input logic [ADDR_W-1:0] hyp_addr,
  input logic [31:0]       hyp_synd
);

  assert_onehot_sel_R10: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> $countones(exc_sel) == 1);

  assert_no_strobe_no_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !flt_valid |=> !exc_valid);

  assert_illegal_kind_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && acc_kind == 2'd3) |=>
      (!exc_valid && $stable(sup_addr) && $stable(sup_synd)
       && $stable(hyp_addr) && $stable(hyp_synd) && $stable(err_code)));

  assert_data_err_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && (exc_sel[2] || exc_sel[3])) |-> err_code == 32'd0);

  assert_hdsi_keeps_sup_R3: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_sel[3]) |-> ($stable(sup_addr) && $stable(sup_synd)));

  assert_dsi_keeps_hyp_R3: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_sel[2]) |-> ($stable(hyp_addr) && $stable(hyp_synd)));

  assert_hv_stays_sup_R1: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && msr_hv) |=> (!exc_valid || !(exc_sel[1] || exc_sel[3])));

  assert_zero_partition_sup_R2: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !part_vpm0 && !part_vpm1) |=> (!exc_valid || !(exc_sel[1] || exc_sel[3])));

endmodule

bind mmu_fault_router mfr_checker #(.ADDR_W(ADDR_W)) u_mfr_checker (
  .clk       (clk),
  .rst       (rst),
  .flt_valid (flt_valid),
  .acc_kind  (acc_kind),
  .msr_hv    (msr_hv),
  .part_vpm0 (part_vpm0),
  .part_vpm1 (part_vpm1),
  .exc_valid (exc_valid),
  .exc_sel   (exc_sel),
  .err_code  (err_code),
  .sup_addr  (sup_addr),
  .sup_synd  (sup_synd),
  .hyp_addr  (hyp_addr),
  .hyp_synd  (hyp_synd)
);

// File: tb/tb_mmu_fault_router.sv
module tb_mmu_fault_router;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flt_valid = 1'b0;
  logic [1:0]    acc_kind = 2'd0;
  logic          seg_noexec = 1'b0, pte_miss = 1'b0, pp_deny = 1'b0, amr_deny = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic          msr_ir = 1'b0, msr_dr = 1'b0, msr_hv = 1'b0;
  logic          part_vpm0 = 1'b0, part_vpm1 = 1'b0;
  logic          exc_valid;
  logic [3:0]    exc_sel;
  logic [31:0]   err_code, sup_synd, hyp_synd;
  logic [AW-1:0] sup_addr, hyp_addr;

  mmu_fault_router #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .acc_kind(acc_kind),
    .seg_noexec(seg_noexec), .pte_miss(pte_miss), .pp_deny(pp_deny),
    .amr_deny(amr_deny), .flt_addr(flt_addr), .msr_ir(msr_ir),
    .msr_dr(msr_dr), .msr_hv(msr_hv), .part_vpm0(part_vpm0),
    .part_vpm1(part_vpm1), .exc_valid(exc_valid), .exc_sel(exc_sel),
    .err_code(err_code), .sup_addr(sup_addr), .sup_synd(sup_synd),
    .hyp_addr(hyp_addr), .hyp_synd(hyp_synd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R12";
  bit    done = 1'b0;

  // reference state
  logic          m_valid = 1'b0;
  logic [3:0]    m_sel = '0;
  logic [31:0]   m_err = '0, m_ssy = '0, m_hsy = '0;
  logic [AW-1:0] m_sad = '0, m_had = '0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_sel = 0; m_err = 0; m_ssy = 0; m_hsy = 0; m_sad = 0; m_had = 0;
    end else begin
      bit          found;
      logic [31:0] code;
      bit          fetch, hypv, sel_bit;
      found = 0; code = 0;
      fetch = (acc_kind == 2);
      m_valid = 0;
      if (flt_valid && acc_kind != 3) begin
        if (fetch) begin
          if (seg_noexec)              begin found = 1; code = 32'h1000_0000; end
          else if (pte_miss)           begin found = 1; code = 32'h4000_0000; end
          else if (pp_deny | amr_deny) begin found = 1; code = 32'h0800_0000; end
        end else begin
          if (pte_miss) begin found = 1; code = 32'h4000_0000; end
          else if (pp_deny | amr_deny) begin
            found = 1;
            if (pp_deny)  code += 32'h0800_0000;
            if (amr_deny) code += 32'h0020_0000;
          end
          if (found && acc_kind == 1) code += 32'h0200_0000;
        end
      end
      if (found) begin
        sel_bit = (fetch ? msr_ir : msr_dr) ? part_vpm1 : part_vpm0;
        hypv = sel_bit && !msr_hv;
        m_valid = 1;
        if (fetch) begin
          m_sel = hypv ? 4'b0010 : 4'b0001;
          m_err = code;
        end else begin
          m_sel = hypv ? 4'b1000 : 4'b0100;
          m_err = 0;
          if (hypv) begin m_had = flt_addr; m_hsy = code; end
          else      begin m_sad = flt_addr; m_ssy = code; end
        end
      end
    end
    #2;
    if (!done) begin
      chk("exc_valid", 64'(exc_valid), 64'(m_valid));
      chk("exc_sel",   64'(exc_sel),   64'(m_sel));
      chk("err_code",  64'(err_code),  64'(m_err));
      chk("sup_addr",  sup_addr,       m_sad);
      chk("sup_synd",  64'(sup_synd),  64'(m_ssy));
      chk("hyp_addr",  hyp_addr,       m_had);
      chk("hyp_synd",  64'(hyp_synd),  64'(m_hsy));
    end
  end

  task automatic fault(input string tag, input logic [1:0] k, input logic ne, input logic ms,
                       input logic pp, input logic am, input logic [3:0] ctl, input logic [1:0] vp);
    @(negedge clk);
    cur_tag = tag;
    flt_valid = 1; acc_kind = k; seg_noexec = ne; pte_miss = ms; pp_deny = pp; amr_deny = am;
    flt_addr = {$urandom, $urandom};
    {msr_ir, msr_dr, msr_hv} = ctl[2:0];
    {part_vpm1, part_vpm0} = vp;
    @(negedge clk);
    flt_valid = 0; seg_noexec = 0; pte_miss = 0; pp_deny = 0; amr_deny = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state checked by the compare block while rst is high
    rst = 0;
    // R1 fetch routing across all mode combinations
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 4; v++) fault("R1", 2'd2, 0, 1, 0, 0, 4'(c), 2'(v));
    // R2 / R3 data routing and register pairs
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 4; v++) fault("R2", 2'd0, 0, 1, 0, 0, 4'(c), 2'(v));
    for (int c = 0; c < 8; c++)
      for (int v = 0; v < 4; v++) fault("R3", 2'd1, 0, 0, 1, 1, 4'(c), 2'(v));
    // R4 error code: fetch carries syndrome, data zero
    fault("R4", 2'd2, 0, 0, 1, 0, 4'b000, 2'b00);
    fault("R4", 2'd1, 0, 1, 0, 0, 4'b000, 2'b00);
    // R5 no-execute on fetch, ignored on data
    fault("R5", 2'd2, 1, 0, 0, 0, 4'b000, 2'b00);
    fault("R5", 2'd0, 1, 0, 0, 0, 4'b000, 2'b00);
    fault("R5", 2'd1, 1, 0, 0, 0, 4'b010, 2'b11);
    // R6 miss syndromes
    fault("R6", 2'd0, 0, 1, 0, 0, 4'b000, 2'b00);
    fault("R6", 2'd1, 0, 1, 0, 0, 4'b000, 2'b00);
    fault("R6", 2'd2, 0, 1, 0, 0, 4'b000, 2'b00);
    // R7 fetch denial
    fault("R7", 2'd2, 0, 0, 0, 1, 4'b000, 2'b00);
    fault("R7", 2'd2, 0, 0, 1, 1, 4'b100, 2'b10);
    // R8 data denial composition
    for (int k = 0; k < 2; k++) begin
      fault("R8", 2'(k), 0, 0, 1, 0, 4'b000, 2'b00);
      fault("R8", 2'(k), 0, 0, 0, 1, 4'b010, 2'b10);
      fault("R8", 2'(k), 0, 0, 1, 1, 4'b000, 2'b01);
    end
    // R9 priority
    fault("R9", 2'd2, 1, 1, 1, 1, 4'b000, 2'b00);
    fault("R9", 2'd2, 0, 1, 1, 1, 4'b000, 2'b00);
    fault("R9", 2'd1, 1, 1, 1, 1, 4'b000, 2'b00);
    // R10 hold between faults
    cur_tag = "R10";
    repeat (5) @(negedge clk);
    // R11 illegal kind and no failing check
    fault("R11", 2'd3, 1, 1, 1, 1, 4'b000, 2'b01);
    fault("R11", 2'd3, 0, 1, 0, 0, 4'b010, 2'b11);
    fault("R11", 2'd0, 0, 0, 0, 0, 4'b000, 2'b00);
    fault("R11", 2'd2, 0, 0, 0, 0, 4'b000, 2'b00);
    // R12 reset mid-run
    @(negedge clk); cur_tag = "R12"; rst = 1;
    @(negedge clk); rst = 0;
    // random mix, back-to-back strobes
    cur_tag = "R9";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      flt_valid = $urandom_range(0, 3) != 0;
      acc_kind = 2'($urandom);
      {seg_noexec, pte_miss, pp_deny, amr_deny} = 4'($urandom);
      {msr_ir, msr_dr, msr_hv, part_vpm1, part_vpm0} = 5'($urandom);
      flt_addr = {$urandom, $urandom};
    end
    @(negedge clk); flt_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule